// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Register Set

This block holds the interrupt state of a serial bus controller. Ten source positions share one bit layout. Nine of them carry events and one position is reserved. A one-cycle event pulse from the controller core latches a sticky status bit. Software clears status bits by writing ones to them. A bit written with zero is left alone, so writing back a value just read clears exactly the bits that were seen.

Masking is never written directly. A mask view can only be read. Two write-only ports change it: the unmask port clears mask bits and the mask port sets them, and in both a zero bit leaves the mask unchanged. A single registered interrupt line goes high when any status bit is set whose mask bit is clear.

Access goes through a simple word port with address, write data, write strobe, read strobe and read data. Read data is combinational while the read strobe is high and zero otherwise.

Top module: `irq_regbank`

## Requirements
- R1: After reset every status bit reads 0. The mask view reads 0x2FF, meaning all nine sources are masked. The interrupt output is 0.
- R2: An event pulse on input bit n sets status bit n in the next cycle, and the bit stays set until it is cleared. The positions are: 0 transfer done, 1 data threshold, 2 no acknowledge, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to the status offset 0x10 clears exactly the status bits written as 1 and leaves all other status bits unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: A write to the unmask offset 0x24 clears the mask bits written as 1. Mask bits written as 0 keep their value.
- R6: A write to the mask offset 0x28 sets the mask bits written as 1. Mask bits written as 0 keep their value.
- R7: The interrupt output in a given cycle equals the OR, over all positions, of (status AND NOT mask) as it stood in the previous cycle.
- R8: Position 8 and all bits at 10 and above always read 0. An event pulse on position 8 has no effect.
- R9: Reading the unmask offset, the mask offset or any unmapped offset returns 0. The read data is 0 whenever the read strobe is low.
- R10: The mask view at offset 0x20 is read-only. A write to it leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | One-cycle event pulses, one per position |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, zero unless reg_rd is high |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The checker assumes that the read and write strobes are never high in the same cycle. It also assumes that event inputs are plain pulses with no relation to the register port, except when a test deliberately makes them coincide. The stimulus drives every input on the falling clock edge, issues each access as a single-strobe cycle, and only combines an event with a write in the dedicated collision test. Sweeps walk every bit position in turn, and the expected values are built in the bench from shifts of the implemented-bit mask.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
   localparam int unsigned SRC_CNT = 10;

   // Event positions; software decodes these, so they are fixed.
   localparam int unsigned POS_DONE    = 0;
   localparam int unsigned POS_THRESH  = 1;
   localparam int unsigned POS_NOACK   = 2;
   localparam int unsigned POS_TMO     = 3;
   localparam int unsigned POS_TGT_RDY = 4;
   localparam int unsigned POS_RX_OVR  = 5;
   localparam int unsigned POS_TX_OVR  = 6;
   localparam int unsigned POS_RX_UND  = 7;
   localparam int unsigned POS_ARB     = 9;

   localparam logic [SRC_CNT-1:0] IMPL_DEFAULT =
      SRC_CNT'((1 << POS_DONE) | (1 << POS_THRESH) | (1 << POS_NOACK) |
               (1 << POS_TMO) | (1 << POS_TGT_RDY) | (1 << POS_RX_OVR) |
               (1 << POS_TX_OVR) | (1 << POS_RX_UND) | (1 << POS_ARB));

   localparam int unsigned OFS_STAT_DEFAULT = 'h10;
   localparam int unsigned OFS_MASK_DEFAULT = 'h20;
   localparam int unsigned OFS_EN_DEFAULT   = 'h24;
   localparam int unsigned OFS_DIS_DEFAULT  = 'h28;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_MASK,
      SEL_EN,
      SEL_DIS
   } reg_sel_e;
endpackage

// File: rtl/irq_status_cell.sv
module irq_status_cell #(
   parameter bit PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic q
);
   generate
      if (PRESENT) begin : g_live
         logic q_r;
         // Set has priority over clear so a colliding pulse is not lost.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= 1'b0;
            else        q_r <= evt | (q_r & ~clr);
         end
         assign q = q_r;
      end else begin : g_tied
         logic unused_tie;
         assign unused_tie = evt ^ clr ^ clk ^ rst_n;
         assign q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned WIDTH = 10,
   parameter logic [WIDTH-1:0] IMPL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             dis_wr,
   input  logic [WIDTH-1:0] bits,
   output logic [WIDTH-1:0] mask
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (IMPL[i]) begin : g_live
         logic m_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 m_r <= 1'b1;
            else if (dis_wr && bits[i]) m_r <= 1'b1;
            else if (en_wr && bits[i])  m_r <= 1'b0;
         end
         assign mask[i] = m_r;
      end else begin : g_tied
         assign mask[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_regbank_pkg::*;
#(
   parameter int unsigned WIDTH  = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic              rd,
   input  reg_sel_e          sel,
   input  logic [WIDTH-1:0]  stat,
   input  logic [WIDTH-1:0]  mask,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            SEL_STAT: rdata[WIDTH-1:0] = stat;
            SEL_MASK: rdata[WIDTH-1:0] = mask;
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
   import irq_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_SRC  = SRC_CNT,
   parameter logic [NUM_SRC-1:0] IMPL = IMPL_DEFAULT,
   parameter int unsigned OFS_STAT = OFS_STAT_DEFAULT,
   parameter int unsigned OFS_MASK = OFS_MASK_DEFAULT,
   parameter int unsigned OFS_EN   = OFS_EN_DEFAULT,
   parameter int unsigned OFS_DIS  = OFS_DIS_DEFAULT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_wr,
   input  logic               reg_rd,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_o
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (NUM_SRC > DATA_W) begin : g_chk_width
      $error("irq_regbank: NUM_SRC exceeds DATA_W");
   end
   if (OFS_STAT >= ADDR_SPAN || OFS_MASK >= ADDR_SPAN ||
       OFS_EN >= ADDR_SPAN || OFS_DIS >= ADDR_SPAN) begin : g_chk_span
      $error("irq_regbank: offset outside address range");
   end
   if (OFS_STAT == OFS_MASK || OFS_STAT == OFS_EN || OFS_STAT == OFS_DIS ||
       OFS_MASK == OFS_EN || OFS_MASK == OFS_DIS || OFS_EN == OFS_DIS) begin : g_chk_uniq
      $error("irq_regbank: offsets collide");
   end

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] stat_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               wr_stat, wr_en, wr_dis;
   logic               irq_r;

   always_comb begin
      if      (reg_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (reg_addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
      else if (reg_addr == ADDR_W'(OFS_EN))   sel = SEL_EN;
      else if (reg_addr == ADDR_W'(OFS_DIS))  sel = SEL_DIS;
      else                                    sel = SEL_NONE;
   end

   assign wbits   = reg_wdata[NUM_SRC-1:0];
   assign wr_stat = reg_wr && (sel == SEL_STAT);
   assign wr_en   = reg_wr && (sel == SEL_EN);
   assign wr_dis  = reg_wr && (sel == SEL_DIS);
   assign clr_vec = wr_stat ? wbits : '0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
      irq_status_cell #(.PRESENT(IMPL[i])) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt_i[i]),
         .clr   (clr_vec[i]),
         .q     (stat_q[i])
      );
   end

   irq_mask_reg #(.WIDTH(NUM_SRC), .IMPL(IMPL)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (wr_en),
      .dis_wr (wr_dis),
      .bits   (wbits),
      .mask   (mask_q)
   );

   irq_read_mux #(.WIDTH(NUM_SRC), .DATA_W(DATA_W)) u_rmux (
      .rd    (reg_rd),
      .sel   (sel),
      .stat  (stat_q),
      .mask  (mask_q),
      .rdata (reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_r <= 1'b0;
      else        irq_r <= |(stat_q & ~mask_q);
   end
   assign irq_o = irq_r;

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_SRC  = 10,
   parameter logic [NUM_SRC-1:0] IMPL = '1,
   parameter int unsigned OFS_STAT = 'h10,
   parameter int unsigned OFS_EN   = 'h24,
   parameter int unsigned OFS_DIS  = 'h28
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic               reg_wr,
   input logic               reg_rd,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] mask_q
);
   logic [NUM_SRC-1:0] wb;
   assign wb = reg_wdata[NUM_SRC-1:0];

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

   assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));

   assert_clear_keeps_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_STAT)) |=>
         ((stat_q & $past(stat_q & ~wb)) == $past(stat_q & ~wb)));

   assert_en_unmasks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_EN)) |=> ((mask_q & $past(wb)) == '0));

   assert_dis_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_DIS)) |=>
         ((mask_q & $past(wb & IMPL)) == $past(wb & IMPL)));

   assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~mask_q) != '0) |=> irq_o);

   assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~mask_q) == '0) |=> !irq_o);

   assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q | mask_q) & ~IMPL) == '0);

   assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |-> (reg_rdata == '0));
endmodule

bind irq_regbank irq_regbank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .IMPL(IMPL),
   .OFS_STAT(OFS_STAT), .OFS_EN(OFS_EN), .OFS_DIS(OFS_DIS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_rdata(reg_rdata), .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/irq_regbank_test.sv
module irq_regbank_test;
   localparam int unsigned N = 10;
   localparam logic [31:0] IMPL = 32'((1 << N) - 1) & ~32'(1 << 8);
   localparam logic [7:0] A_STAT = 8'h10, A_MASK = 8'h20, A_EN = 8'h24, A_DIS = 8'h28;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt_i = '0;
   logic [7:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic         reg_wr = 1'b0;
   logic         reg_rd = 1'b0;
   logic [31:0]  reg_rdata;
   logic         irq_o;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   irq_regbank uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(logic [7:0] a, string req, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #2 check(req, reg_rdata, exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(logic [N-1:0] v);
      @(negedge clk);
      evt_i = v;
      @(negedge clk);
      evt_i = '0;
   endtask

   initial begin
      #4_000_000;
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(A_STAT, "R1", 32'h0);
      rd(A_MASK, "R1", IMPL);
      check("R1 irq", 32'(irq_o), 32'h0);

      // R2/R8 per-position set
      for (int b = 0; b < N; b++) begin
         pulse(N'(1 << b));
         rd(A_STAT, "R2/R8 set", IMPL & 32'(1 << b));
         check("R8 masked irq", 32'(irq_o), 32'h0);
         wr(A_STAT, 32'hFFFF_FFFF);
         rd(A_STAT, "R3 clear all", 32'h0);
      end

      // R3 walking clear
      pulse('1);
      rd(A_STAT, "R2 all", IMPL);
      for (int b = 0; b < N; b++) begin
         wr(A_STAT, 32'(1 << b));
         rd(A_STAT, "R3 walk", IMPL & ~32'((2 << b) - 1));
      end

      // R5/R6/R7 per-position enable and disable
      for (int b = 0; b < N; b++) begin
         if (IMPL[b]) begin
            pulse(N'(1 << b));
            wr(A_EN, 32'(1 << b));
            // status and mask settled at last edge; irq follows one edge later
            @(negedge clk);
            check("R7 rise", 32'(irq_o), 32'h1);
            rd(A_MASK, "R5 unmask", IMPL & ~32'(1 << b));
            wr(A_EN, 32'h0);
            rd(A_MASK, "R5 zero write", IMPL & ~32'(1 << b));
            wr(A_DIS, 32'h0);
            rd(A_MASK, "R6 zero write", IMPL & ~32'(1 << b));
            wr(A_MASK, 32'hFFFF_FFFF);
            rd(A_MASK, "R10 read-only", IMPL & ~32'(1 << b));
            wr(A_STAT, 32'(1 << b));
            check("R7 lag", 32'(irq_o), 32'h1);
            @(negedge clk);
            check("R7 fall", 32'(irq_o), 32'h0);
            wr(A_DIS, 32'(1 << b));
            rd(A_MASK, "R6 mask", IMPL);
         end
      end

      // R4 collision: event wins over clear
      pulse(N'(1 << 3));
      @(negedge clk);
      reg_addr = A_STAT; reg_wdata = 32'h0000_0208; reg_wr = 1'b1;
      evt_i = N'(1 << 3);
      @(negedge clk);
      reg_wr = 1'b0; evt_i = '0;
      rd(A_STAT, "R4", 32'h8);
      wr(A_STAT, 32'h8);

      // R8 position 8 event ignored, R9 write-only and unmapped reads
      pulse(N'(1 << 8));
      rd(A_STAT, "R8", 32'h0);
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_MASK, "R8 mask", 32'h0);
      rd(A_EN, "R9 en read", 32'h0);
      rd(A_DIS, "R9 dis read", 32'h0);
      rd(8'h00, "R9 unmapped", 32'h0);
      pulse('1);
      @(negedge clk);
      check("R9 idle rdata", reg_rdata, 32'h0);
      check("R7 all", 32'(irq_o), 32'h1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule